// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether an incoming Ethernet frame is kept, based only on its 48-bit destination address. A `start` pulse hands over the destination address, the station's own address and four accept-enable bits. The block then runs a CRC-32 over the six address bytes, one byte per clock. The top six bits of that CRC pick one bit out of a 64-bit multicast hash table. After the last byte it emits a single-cycle `done` pulse carrying the accept decision and three classification flags: broadcast, own-address match and multicast.

Software loads the hash table as two 32-bit words. A layout input chooses how those words map onto the 64 table bits. In the plain layout, word 0 holds table bits 31:0. In the alternative layout, each word is byte-reversed and the two words trade places. Frame parsing, FCS checking and data movement are handled elsewhere. The block only sees addresses.

Top module: `mhf_addr_filter`

## Requirements
- R1: The CRC register is seeded with all ones. Address bytes are consumed first byte first (the first byte is `dst_addr[47:40]`), and within each byte least significant bit first. On each bit the feedback is CRC bit 31 XOR the data bit. The register shifts left by one, and when the feedback is 1 it is XORed with 0x04C11DB7.
- R2: Bits 31:26 of the final CRC form an index 0..63 that selects one bit of the 64-bit hash table.
- R3: With `hash_swap`=0, a write with `hash_wr_hi`=0 sets table bits 31:0 and a write with `hash_wr_hi`=1 sets table bits 63:32, bit for bit.
- R4: With `hash_swap`=1, table bits 63:32 are the hi=0 word with its four bytes reversed, and table bits 31:0 are the hi=1 word with its bytes reversed.
- R5: `accept_cfg[0]` set makes every frame accepted.
- R6: `is_phys` is 1 when the destination equals `station_addr`. Such a frame is accepted when `accept_cfg[1]` is set.
- R7: `is_bcast` is 1 when the destination is all ones. Such a frame is accepted when `accept_cfg[3]` is set. A broadcast frame is never flagged as multicast.
- R8: `is_mcast` is 1 when bit 40 of the destination (bit 0 of the first byte) is 1 and the address is not all ones. Such a frame is accepted only when `accept_cfg[2]` is set and the indexed hash bit is 1.
- R9: All three flags reflect the address whatever the accept bits are, and `accept` is the OR of the four accept terms.
- R10: `done` is high for exactly one cycle, seven clock edges after the edge that took `start`. `accept` and the flags are valid with `done` and are 0 in every other cycle.
- R11: While `busy` is high, `start` is ignored, and the frame in flight completes with its own captured inputs.
- R12: Reset clears the hash table and leaves `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup; inputs below are captured on this edge |
| dst_addr | input | 48 | Destination address, first byte in bits 47:40 |
| station_addr | input | 48 | Own station address, same byte order |
| accept_cfg | input | 4 | Accept enables: 0 all, 1 own address, 2 multicast, 3 broadcast |
| hash_wr_en | input | 1 | Write one hash word this cycle |
| hash_wr_hi | input | 1 | Selects word 1 (offset 4) when 1, word 0 (offset 0) when 0 |
| hash_wr_data | input | 32 | Hash word data |
| hash_swap | input | 1 | Selects the byte-reversed, word-swapped table layout |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| accept | output | 1 | Frame accepted |
| is_bcast | output | 1 | Broadcast destination |
| is_phys | output | 1 | Destination equals station address |
| is_mcast | output | 1 | Multicast (non-broadcast) destination |

## Verification
The bench targets the bit and byte ordering of the CRC. A wrong bit or byte order, or a wrong polynomial, selects a different hash bit, so single-bit tables reject frames that a correct design accepts. It also exercises both hash layouts with asymmetric words, which exposes a missing byte reversal or word swap. The all-ones address is run with the multicast enable only, where a design that counts broadcast as multicast would accept on a set hash bit. Finally, a second `start` is injected mid-lookup with accept-all settings; a design that restarts or recaptures its inputs would change the result or the `done` timing.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int CRC_W      = 32;
    localparam int IDX_W      = 6;
    localparam int HASH_W     = 1 << IDX_W;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int CFG_W      = 4;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

    localparam logic [CRC_W-1:0] CRC_SEED      = '1;
    localparam logic [CRC_W-1:0] CRC_TAP_NOLSB = 32'h04C1_1DB6;

    typedef enum int unsigned {
        CFG_ALL   = 0,
        CFG_OWN   = 1,
        CFG_MCAST = 2,
        CFG_BCAST = 3
    } cfg_pos_e;

    typedef struct packed {
        logic bcast;
        logic phys;
        logic mcast;
    } match_t;

    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] sta;
        logic [CFG_W-1:0]  cfg;
    } frame_ctx_t;

    function automatic logic [CRC_W-1:0] crc_bit_step(
        input logic [CRC_W-1:0] crc,
        input logic             din
    );
        logic             fb;
        logic [CRC_W-1:0] nxt;
        fb  = crc[CRC_W-1] ^ din;
        nxt = {crc[CRC_W-2:0], 1'b0};
        if (fb) begin
            nxt = (nxt ^ CRC_TAP_NOLSB) | {{(CRC_W-1){1'b0}}, 1'b1};
        end
        return nxt;
    endfunction

    function automatic logic [CRC_W-1:0] crc_byte_step(
        input logic [CRC_W-1:0]  crc,
        input logic [BYTE_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        c = crc;
        for (int b = 0; b < BYTE_W; b++) begin
            c = crc_bit_step(c, data[b]);
        end
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] addr_byte(
        input logic [ADDR_W-1:0] addr,
        input logic [CNT_W-1:0]  k
    );
        logic [ADDR_W-1:0] sh;
        sh = addr >> (BYTE_W * (ADDR_BYTES - 1 - int'(k)));
        return sh[BYTE_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] rev_bytes(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_BYTES; i++) begin
            r[i*BYTE_W +: BYTE_W] = w[(WORD_BYTES-1-i)*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
    import mhf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    localparam int AW     = N_BYTES * BYTE_W,
    localparam int CW     = $clog2(N_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [AW-1:0]    addr_in,
    output logic             launch,
    output logic             busy,
    output logic             crc_valid,
    output logic [CRC_W-1:0] crc_out
);

    logic [CW-1:0]    step_q;
    logic [AW-1:0]    addr_q;
    logic [CRC_W-1:0] crc_q;
    logic [BYTE_W-1:0] cur_byte;

    localparam logic [CW-1:0] LAST = CW'(N_BYTES);

    assign busy      = (step_q != '0);
    assign launch    = start && !busy;
    assign crc_valid = (step_q == LAST);
    assign crc_out   = crc_q;

    always_comb begin
        logic [AW-1:0] sh;
        sh       = addr_q >> (BYTE_W * (N_BYTES - 1 - int'(step_q)));
        cur_byte = sh[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            addr_q <= '0;
            crc_q  <= CRC_SEED;
        end else if (launch) begin
            addr_q <= addr_in;
            crc_q  <= crc_byte_step(CRC_SEED, addr_in[AW-1 -: BYTE_W]);
            step_q <= CW'(1);
        end else if (busy && !crc_valid) begin
            crc_q  <= crc_byte_step(crc_q, cur_byte);
            step_q <= step_q + CW'(1);
        end else if (crc_valid) begin
            step_q <= '0;
        end
    end

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
    import mhf_pkg::*;
#(
    parameter int TBL_IDX_W = IDX_W,
    localparam int TBL_W    = 1 << TBL_IDX_W,
    localparam int N_WORDS  = TBL_W / WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_hi,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 swap,
    input  logic [TBL_IDX_W-1:0] idx,
    output logic                 hit
);

    logic [WORD_W-1:0] word_q [N_WORDS];
    logic [TBL_W-1:0]  plain_tbl;
    logic [TBL_W-1:0]  swap_tbl;
    logic [TBL_W-1:0]  tbl;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[w] <= '0;
            end else if (wr_en && (int'(wr_hi) == w)) begin
                word_q[w] <= wr_data;
            end
        end
        assign plain_tbl[w*WORD_W +: WORD_W] = word_q[w];
        assign swap_tbl[(N_WORDS-1-w)*WORD_W +: WORD_W] = rev_bytes(word_q[w]);
    end

    assign tbl = swap ? swap_tbl : plain_tbl;
    assign hit = tbl[idx];

endmodule

// File: rtl/mhf_accept_logic.sv
module mhf_accept_logic
    import mhf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  frame_ctx_t       ctx,
    input  logic             crc_valid,
    input  logic [CRC_W-1:0] crc,
    input  logic             hash_hit,
    output logic [IDX_W-1:0] hash_idx,
    output logic             done,
    output logic             accept,
    output match_t           match
);

    match_t m_c;
    logic   acc_c;

    assign hash_idx = crc[CRC_W-1 -: IDX_W];

    always_comb begin
        m_c.bcast = &ctx.dst;
        m_c.phys  = (ctx.dst == ctx.sta);
        m_c.mcast = ctx.dst[ADDR_W-BYTE_W] && !m_c.bcast;
        acc_c = ctx.cfg[CFG_ALL]
              | (m_c.phys  & ctx.cfg[CFG_OWN])
              | (m_c.bcast & ctx.cfg[CFG_BCAST])
              | (m_c.mcast & ctx.cfg[CFG_MCAST] & hash_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            accept <= 1'b0;
            match  <= '0;
        end else begin
            done   <= crc_valid;
            accept <= crc_valid && acc_c;
            match  <= crc_valid ? m_c : '0;
        end
    end

endmodule

// File: rtl/mhf_addr_filter.sv
module mhf_addr_filter
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [CFG_W-1:0]  accept_cfg,
    input  logic              hash_wr_en,
    input  logic              hash_wr_hi,
    input  logic [WORD_W-1:0] hash_wr_data,
    input  logic              hash_swap,
    output logic              busy,
    output logic              done,
    output logic              accept,
    output logic              is_bcast,
    output logic              is_phys,
    output logic              is_mcast
);

    logic             launch;
    logic             crc_valid;
    logic [CRC_W-1:0] crc;
    logic [IDX_W-1:0] hash_idx;
    logic             hash_hit;
    frame_ctx_t       ctx_q;
    match_t           match;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (launch) begin
            ctx_q.dst <= dst_addr;
            ctx_q.sta <= station_addr;
            ctx_q.cfg <= accept_cfg;
        end
    end

    mhf_crc_engine #(.N_BYTES(ADDR_BYTES)) u_crc (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .addr_in   (dst_addr),
        .launch    (launch),
        .busy      (busy),
        .crc_valid (crc_valid),
        .crc_out   (crc)
    );

    mhf_hash_table #(.TBL_IDX_W(IDX_W)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hash_wr_en),
        .wr_hi   (hash_wr_hi),
        .wr_data (hash_wr_data),
        .swap    (hash_swap),
        .idx     (hash_idx),
        .hit     (hash_hit)
    );

    mhf_accept_logic u_acc (
        .clk       (clk),
        .rst       (rst),
        .ctx       (ctx_q),
        .crc_valid (crc_valid),
        .crc       (crc),
        .hash_hit  (hash_hit),
        .hash_idx  (hash_idx),
        .done      (done),
        .accept    (accept),
        .match     (match)
    );

    assign is_bcast = match.bcast;
    assign is_phys  = match.phys;
    assign is_mcast = match.mcast;

endmodule

// File: rtl/mhf_addr_filter_chk.sv
module mhf_addr_filter_chk
    import mhf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CFG_W-1:0] accept_cfg,
    input logic             busy,
    input logic             done,
    input logic             accept,
    input logic             is_bcast,
    input logic             is_phys,
    input logic             is_mcast
);

    // R10: single-cycle strobe
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: seven edges from the taken start to the strobe
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start && !busy, 7));

    // R10: outputs quiet outside the strobe
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        !done |-> !(accept || is_bcast || is_phys || is_mcast));

    // R7, R8: broadcast never counted as multicast
    a_r7_bcast_not_mcast: assert property (@(posedge clk) disable iff (rst)
        done |-> !(is_bcast && is_mcast));

    // R5: accept-all captured at start forces acceptance
    a_r5_accept_all: assert property (@(posedge clk) disable iff (rst)
        (done && $past(start && !busy && accept_cfg[CFG_ALL], 7)) |-> accept);

    // R11: a taken start makes the block busy
    a_r11_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

bind mhf_addr_filter mhf_addr_filter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .accept_cfg (accept_cfg),
    .busy       (busy),
    .done       (done),
    .accept     (accept),
    .is_bcast   (is_bcast),
    .is_phys    (is_phys),
    .is_mcast   (is_mcast)
);

// File: tb/mhf_addr_filter_tb_top.sv
module mhf_addr_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [47:0] dst_addr = '0;
    logic [47:0] station_addr = '0;
    logic [3:0]  accept_cfg = '0;
    logic        hash_wr_en = 1'b0;
    logic        hash_wr_hi = 1'b0;
    logic [31:0] hash_wr_data = '0;
    logic        hash_swap = 1'b0;
    logic        busy, done, accept, is_bcast, is_phys, is_mcast;

    int checks = 0;
    int fails  = 0;
    logic [31:0] w0 = '0;
    logic [31:0] w1 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mhf_addr_filter dut_i (
        .clk(clk), .rst(rst), .start(start), .dst_addr(dst_addr),
        .station_addr(station_addr), .accept_cfg(accept_cfg),
        .hash_wr_en(hash_wr_en), .hash_wr_hi(hash_wr_hi),
        .hash_wr_data(hash_wr_data), .hash_swap(hash_swap),
        .busy(busy), .done(done), .accept(accept),
        .is_bcast(is_bcast), .is_phys(is_phys), .is_mcast(is_mcast)
    );

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  b;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            b = a[47 - 8*k -: 8];
            for (int j = 0; j < 8; j++) begin
                fb = c[31] ^ b[j];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        end
        return c;
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [63:0] ref_table(input logic [31:0] a0,
                                              input logic [31:0] a1,
                                              input logic sw);
        return sw ? {bswap(a0), bswap(a1)} : {a1, a0};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic hi, input logic [31:0] d);
        @(negedge clk);
        hash_wr_en = 1'b1; hash_wr_hi = hi; hash_wr_data = d;
        if (hi) w1 = d; else w0 = d;
        @(negedge clk);
        hash_wr_en = 1'b0;
    endtask

    task automatic run_frame(input logic [47:0] d, input logic [47:0] s,
                             input logic [3:0] cfg, input logic intrude,
                             input string req);
        logic [63:0] tbl;
        logic [31:0] c;
        logic eb, ep, em, ea, early;
        tbl = ref_table(w0, w1, hash_swap);
        c   = ref_crc(d);
        eb  = (d == '1);
        ep  = (d == s);
        em  = d[40] && !eb;
        ea  = cfg[0] | (ep & cfg[1]) | (eb & cfg[3]) | (em & cfg[2] & tbl[c[31:26]]);
        early = 1'b0;
        @(negedge clk);
        start = 1'b1; dst_addr = d; station_addr = s; accept_cfg = cfg;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            start = 1'b0;
            if (intrude && n == 3) begin
                start = 1'b1; dst_addr = ~d; accept_cfg = 4'hF;
            end
            if (n < 7 && done) early = 1'b1;
            if (n == 7) begin
                chk({req, " R10 done timing"}, {early, done}, 2'b01);
                chk({req, " R9 accept"}, accept, ea);
                chk({req, " R7 bcast flag"}, is_bcast, eb);
                chk({req, " R6 phys flag"}, is_phys, ep);
                chk({req, " R8 mcast flag"}, is_mcast, em);
            end
            if (n == 8) begin
                chk({req, " R10 strobe ends, outputs cleared"},
                    {done, accept, is_bcast, is_phys, is_mcast}, 5'b0);
            end
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] sta, ma, d;
        logic [31:0] c;
        logic [3:0]  cfg;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        sta = 48'h0012_3456_789A;

        // R12: reset state, and reset clears a loaded table
        repeat (3) @(negedge clk);
        chk("R12 reset outputs", {busy, done, accept}, 3'b0);
        rst = 1'b0;
        write_word(1'b0, 32'hFFFF_FFFF);
        write_word(1'b1, 32'hFFFF_FFFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        w0 = '0; w1 = '0;
        run_frame(48'h0100_5E00_0001, sta, 4'b0100, 1'b0, "R12 table cleared");

        // R8: multicast with empty table is rejected; flags independent of cfg (R9)
        run_frame(48'h0100_5E00_00FB, sta, 4'b0000, 1'b0, "R9 no enables");

        // R1 R2 R3: set only the indexed bit, plain layout
        ma = 48'h3300_0000_0016;
        c  = ref_crc(ma);
        if (c[31:26] < 32) write_word(1'b0, 32'h1 << c[31:26]);
        else               write_word(1'b1, 32'h1 << (c[31:26] - 32));
        run_frame(ma, sta, 4'b0100, 1'b0, "R1 R2 R3 single hash bit");
        run_frame(ma ^ 48'h0000_0000_0100, sta, 4'b0100, 1'b0, "R1 neighbour address");

        // R4: swapped layout with asymmetric words
        write_word(1'b0, 32'h0102_0408);
        write_word(1'b1, 32'h1020_4080);
        hash_swap = 1'b1;
        for (int i = 0; i < 20; i++) begin
            run_frame({8'h01, 8'(i), 32'hA5A5_0000 | i}, sta, 4'b0100, 1'b0, "R4 swap layout");
        end
        hash_swap = 1'b0;
        for (int i = 0; i < 20; i++) begin
            run_frame({8'h01, 8'(i), 32'hA5A5_0000 | i}, sta, 4'b0100, 1'b0, "R3 plain layout");
        end

        // R7: broadcast with full table, multicast enable only -> reject
        write_word(1'b0, 32'hFFFF_FFFF);
        write_word(1'b1, 32'hFFFF_FFFF);
        run_frame(48'hFFFF_FFFF_FFFF, sta, 4'b0100, 1'b0, "R7 bcast not mcast");
        run_frame(48'hFFFF_FFFF_FFFF, sta, 4'b1000, 1'b0, "R7 bcast enabled");

        // R6: own address
        run_frame(sta, sta, 4'b0010, 1'b0, "R6 own enabled");
        run_frame(sta, sta, 4'b1100, 1'b0, "R6 own disabled");

        // R5: accept all
        run_frame(48'h0200_0000_0001, sta, 4'b0001, 1'b0, "R5 accept all");
        run_frame(48'h0200_0000_0001, sta, 4'b1110, 1'b0, "R5 unicast other");

        // R11: start while busy ignored
        run_frame(48'h0200_0000_0002, sta, 4'b0000, 1'b1, "R11 ignored start");
        run_frame(48'h0100_0000_0007, sta, 4'b0000, 1'b1, "R11 ignored start mcast");

        // random mix
        for (int i = 0; i < 300; i++) begin
            if (i % 50 == 0) begin
                write_word(1'b0, $urandom);
                write_word(1'b1, $urandom);
                hash_swap = $urandom_range(0, 1);
            end
            d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            case ($urandom_range(0, 5))
                0: d = sta;
                1: d = '1;
                2, 3: d[40] = 1'b1;
                default: ;
            endcase
            cfg = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) != 0) cfg[0] = 1'b0;
            run_frame(d, sta, cfg, 1'($urandom_range(0, 7) == 0), "R8 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule